// File: doc/BRIEF.md
# Auto-Baud Sync Character Detector

This block listens to an idle-high asynchronous receive line after reset and measures the first character that arrives. The character must be the sync value 0x86. It is sent with one start bit, eight data bits LSB first, and one stop bit. For that value the line shows four transitions inside the frame, in this order:

- the falling edge at the start bit, called the anchor;
- a rising edge two bit times later;
- a falling edge four bit times after the anchor;
- a rising edge eight bit times after the anchor, at data bit 7.

A free-running saturating counter is restarted on the anchor. It is sampled at each later transition. From those samples the block decides whether the pattern fits UART framing, and derives the bit period in clock cycles.

On success the block raises a lock flag, presents the bit period, and emits a one-cycle request for a transmitter to echo the sync byte. On failure it raises an error flag and rearms by itself. It then waits for the line to sit idle before it accepts a new anchor. A rearm pulse clears the lock and starts the detector again. While the block is locked it ignores all activity on the line.

Top module: `auto_baud_detect`

## Requirements
- R1: The receive line passes through a two-flop synchronizer, and all edge timestamps are whole clock-cycle distances from the anchor falling edge. Writing a for the anchor-to-first-rise distance, b for the rise-to-fall distance and c for the fall-to-final-rise distance, the three stamps are a, a+b and a+b+c.
- R2: The frame is accepted (`lock_o`=1, `err_o`=0) when the first-rise stamp is not larger than the gap between the second falling edge and the final rising edge (a <= c). If the first-rise stamp is larger, `err_o` is raised instead.
- R3: On acceptance, `bit_period_o` equals (final-rise stamp + 4) >> 3, which rounds to the nearest whole cycle.
- R4: A computed bit period below MIN_PERIOD (default 4) is an error, and `lock_o` stays low.
- R5: If the counter reaches its all-ones value (0xFFFF by default) before the final rising edge, `err_o` is raised.
- R6: After an error the detector rearms without a rearm pulse. It waits for IDLE_CYC (default 16) consecutive synchronized high samples, then accepts a new anchor.
- R7: While `lock_o` is high and no rearm is given, line activity has no effect: `lock_o`, `bit_period_o` and the echo request do not change.
- R8: A rearm pulse clears `lock_o` and `err_o` on the next clock edge and keeps `bit_period_o`.
- R9: Each acceptance produces exactly one single-cycle `echo_req_o` pulse, in the cycle `lock_o` rises, with `echo_byte_o` = 0x86.
- R10: After reset, `lock_o`, `err_o`, `echo_req_o` and `bit_period_o` are all zero.
- R11: `lock_o` and `err_o` are never high together.
- R12: A falling edge that arrives before the idle wait has completed is not taken as an anchor.
- R13: `bit_period_o` changes only on acceptance; a rejected frame leaves the value from the previous acceptance in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | One-cycle pulse that restarts detection |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| lock_o | output | 1 | Sync character accepted |
| err_o | output | 1 | Last attempt rejected (pattern, minimum period or overflow) |
| bit_period_o | output | CW (16) | Measured bit period in clock cycles |
| echo_req_o | output | 1 | One-cycle request to transmit the echo byte |
| echo_byte_o | output | 8 | Byte to echo, 0x86 |

## Verification
A wrong state in the detector shows at the ports on the first evaluation after the final edge. An anchor taken too early or a lost transition gives either a wrong `bit_period_o` or the wrong choice between `lock_o` and `err_o`, within a few cycles of the frame's last edge. A stuck idle counter or a missing saturation check shows as neither flag rising, long after the frame has ended. The bench uses this by computing the expected flag and period from the three edge gaps it drives, both for jittered random frames and for directed cases. The directed cases cover equality, rounding, the minimum period, overflow, edges that arrive too early, and activity while locked.

// File: rtl/abd_pkg.sv
package abd_pkg;
   localparam logic [7:0] SYNC_CHAR = 8'h86;

   typedef enum logic [2:0] {
      ST_IDLE_WAIT = 3'd0,
      ST_ANCHOR    = 3'd1,
      ST_RISE1     = 3'd2,
      ST_FALL2     = 3'd3,
      ST_RISE2     = 3'd4,
      ST_LOCKED    = 3'd5
   } abd_state_e;
endpackage

// File: rtl/abd_sync2.sv
module abd_sync2 #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/abd_edge_timer.sv
module abd_edge_timer #(
   parameter int CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          line_i,
   input  logic          restart_i,
   output logic          rise_o,
   output logic          fall_o,
   output logic [CW-1:0] stamp_o,
   output logic          sat_o
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   logic          line_d_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_d_q <= 1'b1;
         cnt_q    <= '0;
      end else begin
         line_d_q <= line_i;
         if (restart_i)            cnt_q <= CW'(1);
         else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
      end
   end

   assign rise_o  = ~line_d_q & line_i;
   assign fall_o  = line_d_q & ~line_i;
   assign stamp_o = cnt_q;
   assign sat_o   = (cnt_q == CNT_MAX);
endmodule

// File: rtl/abd_judge.sv
module abd_judge #(
   parameter int CW         = 16,
   parameter int SHIFT      = 3,
   parameter int MIN_PERIOD = 4
) (
   input  logic [CW-1:0] t_rise1_i,
   input  logic [CW-1:0] t_fall2_i,
   input  logic [CW-1:0] t_rise2_i,
   output logic          accept_o,
   output logic [CW-1:0] period_o
);
   localparam logic [CW:0] ROUND = (CW+1)'(1) << (SHIFT-1);

   logic [CW-1:0] gap_cd;
   logic [CW:0]   rounded;

   always_comb begin
      gap_cd   = t_rise2_i - t_fall2_i;
      rounded  = ({1'b0, t_rise2_i} + ROUND) >> SHIFT;
      period_o = rounded[CW-1:0];
      accept_o = (t_rise1_i <= gap_cd) && (period_o >= CW'(MIN_PERIOD));
   end
endmodule

// File: rtl/auto_baud_detect.sv
module auto_baud_detect
   import abd_pkg::*;
#(
   parameter int CW         = 16,
   parameter int SHIFT      = 3,
   parameter int MIN_PERIOD = 4,
   parameter int IDLE_CYC   = 16,
   parameter int SYNC_DEPTH = 2,
   parameter bit ECHO_EN    = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          rearm_i,
   input  logic          rxd_i,
   output logic          lock_o,
   output logic          err_o,
   output logic [CW-1:0] bit_period_o,
   output logic          echo_req_o,
   output logic [7:0]    echo_byte_o
);
   localparam int IW = $clog2(IDLE_CYC + 1);

   if (CW < 8)           begin : g_bad_cw    $error("CW must be at least 8");         end
   if (SHIFT != 3)       begin : g_bad_shift $error("sync pattern spans 8 bit times"); end
   if (IDLE_CYC < 2)     begin : g_bad_idle  $error("IDLE_CYC must be at least 2");   end
   if (SYNC_DEPTH < 2)   begin : g_bad_sync  $error("SYNC_DEPTH must be at least 2"); end
   if (MIN_PERIOD < 1)   begin : g_bad_min   $error("MIN_PERIOD must be positive");   end

   logic          rx_s;
   logic          rise, fall, sat, restart;
   logic [CW-1:0] stamp;
   logic          accept;
   logic [CW-1:0] period_calc;

   abd_state_e    state_q;
   logic [IW-1:0] idle_q;
   logic [CW-1:0] t_r1_q, t_f2_q, period_q;
   logic          lock_q, err_q, echo_q;

   abd_sync2 #(.STAGES(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rxd_i),
      .q_o   (rx_s)
   );

   abd_edge_timer #(.CW(CW)) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (rx_s),
      .restart_i(restart),
      .rise_o   (rise),
      .fall_o   (fall),
      .stamp_o  (stamp),
      .sat_o    (sat)
   );

   abd_judge #(.CW(CW), .SHIFT(SHIFT), .MIN_PERIOD(MIN_PERIOD)) u_judge (
      .t_rise1_i(t_r1_q),
      .t_fall2_i(t_f2_q),
      .t_rise2_i(stamp),
      .accept_o (accept),
      .period_o (period_calc)
   );

   assign restart = (state_q == ST_ANCHOR) && fall && !rearm_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE_WAIT;
         idle_q   <= '0;
         t_r1_q   <= '0;
         t_f2_q   <= '0;
         period_q <= '0;
         lock_q   <= 1'b0;
         err_q    <= 1'b0;
         echo_q   <= 1'b0;
      end else begin
         echo_q <= 1'b0;
         if (rearm_i) begin
            state_q <= ST_IDLE_WAIT;
            idle_q  <= '0;
            lock_q  <= 1'b0;
            err_q   <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE_WAIT: begin
                  if (!rx_s)                          idle_q <= '0;
                  else if (idle_q == IW'(IDLE_CYC-1)) state_q <= ST_ANCHOR;
                  else                                idle_q <= idle_q + IW'(1);
               end
               ST_ANCHOR: if (fall) state_q <= ST_RISE1;
               ST_RISE1: begin
                  if (rise) begin
                     t_r1_q  <= stamp;
                     state_q <= ST_FALL2;
                  end else if (sat) begin
                     err_q   <= 1'b1;
                     idle_q  <= '0;
                     state_q <= ST_IDLE_WAIT;
                  end
               end
               ST_FALL2: begin
                  if (fall) begin
                     t_f2_q  <= stamp;
                     state_q <= ST_RISE2;
                  end else if (sat) begin
                     err_q   <= 1'b1;
                     idle_q  <= '0;
                     state_q <= ST_IDLE_WAIT;
                  end
               end
               ST_RISE2: begin
                  if (rise && accept) begin
                     period_q <= period_calc;
                     lock_q   <= 1'b1;
                     err_q    <= 1'b0;
                     echo_q   <= 1'b1;
                     state_q  <= ST_LOCKED;
                  end else if (rise || sat) begin
                     err_q   <= 1'b1;
                     idle_q  <= '0;
                     state_q <= ST_IDLE_WAIT;
                  end
               end
               ST_LOCKED: state_q <= ST_LOCKED;
               default:   state_q <= ST_IDLE_WAIT;
            endcase
         end
      end
   end

   assign lock_o       = lock_q;
   assign err_o        = err_q;
   assign bit_period_o = period_q;

   if (ECHO_EN) begin : g_echo
      assign echo_req_o  = echo_q;
      assign echo_byte_o = SYNC_CHAR;
   end else begin : g_no_echo
      assign echo_req_o  = 1'b0;
      assign echo_byte_o = 8'h00;
   end
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
   parameter int CW         = 16,
   parameter int MIN_PERIOD = 4
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          rearm_i,
   input logic          lock_o,
   input logic          err_o,
   input logic [CW-1:0] bit_period_o,
   input logic          echo_req_o
);
   assert_flags_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lock_o && err_o));

   assert_min_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o) |-> (bit_period_o >= CW'(MIN_PERIOD)));

   assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_o && !rearm_i) |=> (lock_o && $stable(bit_period_o) && !echo_req_o));

   assert_rearm_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rearm_i |=> (!lock_o && !err_o && $stable(bit_period_o)));

   assert_echo_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      echo_req_o |=> !echo_req_o);

   assert_period_on_accept_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(bit_period_o) |-> $rose(lock_o));
endmodule

bind auto_baud_detect abd_checker #(.CW(CW), .MIN_PERIOD(MIN_PERIOD)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rearm_i     (rearm_i),
   .lock_o      (lock_o),
   .err_o       (err_o),
   .bit_period_o(bit_period_o),
   .echo_req_o  (echo_req_o)
);

// File: tb/auto_baud_detect_tb.sv
`timescale 1ns/1ps
module auto_baud_detect_tb;
   localparam int CW = 16;
   localparam int IDLE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rearm = 1'b0;
   logic          rxd = 1'b1;
   logic          lock, err, echo_req;
   logic [CW-1:0] period;
   logic [7:0]    echo_byte;

   int n_checks = 0;
   int n_errors = 0;
   int echo_cnt = 0;
   int exp_echo = 0;
   int exp_period = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   auto_baud_detect u_dut (
      .clk_i(clk), .rst_ni(rst_n), .rearm_i(rearm), .rxd_i(rxd),
      .lock_o(lock), .err_o(err), .bit_period_o(period),
      .echo_req_o(echo_req), .echo_byte_o(echo_byte)
   );

   always @(posedge clk) if (echo_req) echo_cnt <= echo_cnt + 1;

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_accept(input int a, input int b, input int c);
      int ad = a + b + c;
      return (ad < 65535) && (a <= c) && (((ad + 4) >> 3) >= 4);
   endfunction

   function automatic int exp_per(input int a, input int b, input int c);
      return (a + b + c + 4) >> 3;
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rearm();
      @(negedge clk); rearm = 1'b1;
      @(negedge clk); rearm = 1'b0;
   endtask

   task automatic send(input int a, input int b, input int c);
      @(negedge clk); rxd = 1'b0;
      cycles(a); rxd = 1'b1;
      cycles(b); rxd = 1'b0;
      cycles(c); rxd = 1'b1;
      cycles(12);
   endtask

   task automatic trial(input string tag, input int a, input int b, input int c);
      bit ok = exp_accept(a, b, c);
      send(a, b, c);
      if (ok) begin
         exp_period = exp_per(a, b, c);
         exp_echo++;
      end
      chk({tag, " lock"}, int'(lock), int'(ok));
      chk({tag, " err"},  int'(err),  int'(!ok));
      chk({tag, " period"}, int'(period), exp_period);
      chk({tag, " echo count R9"}, echo_cnt, exp_echo);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      chk("R10 lock", int'(lock), 0);
      chk("R10 err", int'(err), 0);
      chk("R10 period", int'(period), 0);
      chk("R10 echo", int'(echo_req), 0);

      cycles(IDLE + 4);
      trial("R1 R2 R3 T=8", 16, 16, 32);
      chk("R9 echo byte", int'(echo_byte), 'h86);

      send(40, 40, 80);
      chk("R7 lock held", int'(lock), 1);
      chk("R7 period held", int'(period), 8);
      chk("R7 no echo", echo_cnt, exp_echo);

      pulse_rearm();
      chk("R8 lock cleared", int'(lock), 0);
      chk("R8 err cleared", int'(err), 0);
      chk("R8 period kept", int'(period), 8);

      cycles(IDLE + 4);
      trial("R2 R13 reject a>c", 10, 10, 8);
      cycles(IDLE + 4);
      trial("R6 auto rearm T=5", 10, 10, 20);

      pulse_rearm(); cycles(IDLE + 4);
      trial("R4 T=3", 6, 6, 12);
      pulse_rearm(); cycles(IDLE + 4);
      trial("R4 T=4", 8, 8, 16);
      pulse_rearm(); cycles(IDLE + 4);
      trial("R2 equality", 12, 12, 12);
      pulse_rearm(); cycles(IDLE + 4);
      trial("R3 rounding", 10, 10, 13);

      pulse_rearm();
      send(4, 4, 8);
      cycles(20);
      chk("R12 early anchor lock", int'(lock), 0);
      chk("R12 early anchor err", int'(err), 0);
      trial("R12 armed after idle T=6", 12, 12, 24);

      pulse_rearm(); cycles(IDLE + 4);
      @(negedge clk); rxd = 1'b0;
      cycles(10); rxd = 1'b1;
      cycles(65540);
      chk("R5 overflow err", int'(err), 1);
      chk("R5 overflow lock", int'(lock), 0);
      chk("R5 no echo", echo_cnt, exp_echo);

      for (int i = 0; i < 40; i++) begin
         int t = $urandom_range(3, 30);
         int a = 2 * t + $urandom_range(0, 2) - 1;
         int b = 2 * t + $urandom_range(0, 2) - 1;
         int c = 4 * t + $urandom_range(0, 2) - 1;
         if ($urandom_range(0, 3) == 0) a = c + $urandom_range(1, 5);
         pulse_rearm(); cycles(IDLE + 4);
         trial("R1 R2 R3 random", a, b, c);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule